// File: doc/BRIEF.md
# Job-Slot Interrupt and State Registers

This block gathers completion and failure events from sixteen job slots. It records them in a raw interrupt word and gates that word with a mask. The gated result drives a single interrupt line. The lower half of the raw word holds one completion bit per slot, and the upper half holds one failure bit per slot. Software acknowledges events by writing ones to a clear register.

A write to the clear register does one more thing. It folds the written word onto a sixteen-bit slot mask, where a slot counts as affected if either its completion bit or its failure bit was written as one. For each affected slot, the block takes a fresh copy of that slot's live "active job" and "queued next job" flags into a two-bit-per-slot state register. Slots that are not affected keep their state bits.

Accesses at or above the slot base address do not reach the local registers. They go out on a per-slot register port as a slot index and an offset inside that slot's window. Read data for these accesses comes back from the slot port in the same cycle.

Top module: `job_irq_regs`

## Requirements
- R1: After reset, the raw word, the mask and the slot state register are all zero, and irq_o is low.
- R2: done_i[i] high at a clock edge sets raw bit i, and fail_i[i] sets raw bit 16+i.
- R3: A write to the clear register (offset 0x004) clears each raw bit written as one. Reading offset 0x004 returns zero.
- R4: If an event and a clear hit the same raw bit in the same cycle, the bit stays set.
- R5: A write to the raw register (offset 0x000) sets each raw bit written as one and leaves the other bits as they are.
- R6: The mask register (offset 0x008) reads back what was written. The status register (offset 0x00C) reads raw AND mask, and irq_o is high exactly when that value is nonzero.
- R7: On a clear write with data w, let m = w[15:0] | w[31:16]. For every slot i with m[i]=1, state bit i takes active_i[i] and state bit 16+i takes queued_i[i]. All other state bits are kept.
- R8: The state register (offset 0x010) and the status register cannot be written. The state register changes only on a clear write.
- R9: An access with addr_i >= 0x800 raises slot_req_o and forwards we_i and wdata_i. It sets slot_sel_o = addr_i[10:7] and slot_off_o = addr_i[6:0], and rdata_o returns slot_rdata_i. Addresses below 0x800 never raise slot_req_o.
- R10: Local offsets below 0x800 other than the five registers read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| done_i | input | 16 | Per-slot completion event |
| fail_i | input | 16 | Per-slot failure event |
| active_i | input | 16 | Per-slot active job flag |
| queued_i | input | 16 | Per-slot queued next job flag |
| irq_o | output | 1 | Combined interrupt |
| slot_req_o | output | 1 | Forwarded slot access request |
| slot_we_o | output | 1 | Forwarded write enable |
| slot_sel_o | output | 4 | Target slot index |
| slot_off_o | output | 7 | Offset inside the slot window |
| slot_wdata_o | output | 32 | Forwarded write data |
| slot_rdata_i | input | 32 | Read data from the addressed slot |

## Verification
The hardest situation to reach is a clear write that lands in the same cycle as events on some of the bits it clears. The live slot flags must also differ from the stored state, both for affected slots and for unaffected ones. Directed steps set up this collision with a completion event and a failure event. They also write words whose two halves name different slots, so the folding of the halves is visible. After that, a long random phase draws events, flags, masks and clear words from $urandom on every cycle, which covers many overlaps of events and clears.

// File: rtl/job_irq_pkg.sv
package job_irq_pkg;
  localparam logic [11:0] OFF_RAW   = 12'h000;
  localparam logic [11:0] OFF_CLR   = 12'h004;
  localparam logic [11:0] OFF_MASK  = 12'h008;
  localparam logic [11:0] OFF_STAT  = 12'h00C;
  localparam logic [11:0] OFF_STATE = 12'h010;

  typedef enum logic [2:0] {
    SEL_RAW, SEL_CLR, SEL_MASK, SEL_STAT, SEL_STATE, SEL_SLOT, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/job_irq_decode.sv
module job_irq_decode
  import job_irq_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned NSLOT        = 16,
  parameter int unsigned SLOT_BASE    = 'h800,
  parameter int unsigned SLOT_SPAN_LG = 7,
  localparam int unsigned SLOT_W      = $clog2(NSLOT)
) (
  input  logic [ADDR_W-1:0]       addr_i,
  output reg_sel_e                sel_o,
  output logic [SLOT_W-1:0]       slot_o,
  output logic [SLOT_SPAN_LG-1:0] off_o
);
  logic [ADDR_W-1:0] rel;

  assign rel    = addr_i - ADDR_W'(SLOT_BASE);
  assign slot_o = rel[SLOT_SPAN_LG +: SLOT_W];
  assign off_o  = addr_i[SLOT_SPAN_LG-1:0];

  always_comb begin
    if (addr_i >= ADDR_W'(SLOT_BASE))       sel_o = SEL_SLOT;
    else if (addr_i == ADDR_W'(OFF_RAW))    sel_o = SEL_RAW;
    else if (addr_i == ADDR_W'(OFF_CLR))    sel_o = SEL_CLR;
    else if (addr_i == ADDR_W'(OFF_MASK))   sel_o = SEL_MASK;
    else if (addr_i == ADDR_W'(OFF_STAT))   sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(OFF_STATE))  sel_o = SEL_STATE;
    else                                    sel_o = SEL_NONE;
  end
endmodule

// File: rtl/job_irq_status.sv
module job_irq_status #(
  parameter int unsigned NSLOT = 16,
  localparam int unsigned W    = 2 * NSLOT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] sw_set_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  logic [W-1:0] raw_q, mask_q;

  // events are ORed after the clear so they win a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_i) | sw_set_i | evt_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);
endmodule

// File: rtl/job_irq_state.sv
module job_irq_state #(
  parameter int unsigned NSLOT = 16,
  localparam int unsigned W    = 2 * NSLOT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [W-1:0]     clr_word_i,
  input  logic [NSLOT-1:0] active_i,
  input  logic [NSLOT-1:0] queued_i,
  output logic [W-1:0]     state_o
);
  logic [NSLOT-1:0] hit;

  assign hit = clr_word_i[NSLOT-1:0] | clr_word_i[W-1:NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic act_q, que_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q <= 1'b0;
        que_q <= 1'b0;
      end else if (upd_i && hit[i]) begin
        act_q <= active_i[i];
        que_q <= queued_i[i];
      end
    end
    assign state_o[i]         = act_q;
    assign state_o[NSLOT + i] = que_q;
  end
endmodule

// File: rtl/job_irq_regs.sv
module job_irq_regs
  import job_irq_pkg::*;
#(
  parameter int unsigned NSLOT        = 16,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned SLOT_BASE    = 'h800,
  parameter int unsigned SLOT_SPAN_LG = 7,
  localparam int unsigned DATA_W      = 2 * NSLOT,
  localparam int unsigned SLOT_W      = $clog2(NSLOT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [NSLOT-1:0]        done_i,
  input  logic [NSLOT-1:0]        fail_i,
  input  logic [NSLOT-1:0]        active_i,
  input  logic [NSLOT-1:0]        queued_i,
  output logic                    irq_o,
  output logic                    slot_req_o,
  output logic                    slot_we_o,
  output logic [SLOT_W-1:0]       slot_sel_o,
  output logic [SLOT_SPAN_LG-1:0] slot_off_o,
  output logic [DATA_W-1:0]       slot_wdata_o,
  input  logic [DATA_W-1:0]       slot_rdata_i
);
  reg_sel_e          sel;
  logic              wr;
  logic              clr_wr;
  logic [DATA_W-1:0] raw_q, mask_q, state_q;

  job_irq_decode #(
    .ADDR_W(ADDR_W), .NSLOT(NSLOT),
    .SLOT_BASE(SLOT_BASE), .SLOT_SPAN_LG(SLOT_SPAN_LG)
  ) u_dec (
    .addr_i(addr_i), .sel_o(sel), .slot_o(slot_sel_o), .off_o(slot_off_o)
  );

  assign wr     = req_i && we_i;
  assign clr_wr = wr && (sel == SEL_CLR);

  job_irq_status #(.NSLOT(NSLOT)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       ({fail_i, done_i}),
    .sw_set_i    ((wr && sel == SEL_RAW) ? wdata_i : '0),
    .clr_i       (clr_wr ? wdata_i : '0),
    .mask_we_i   (wr && sel == SEL_MASK),
    .mask_wdata_i(wdata_i),
    .raw_o       (raw_q),
    .mask_o      (mask_q),
    .irq_o       (irq_o)
  );

  job_irq_state #(.NSLOT(NSLOT)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (clr_wr),
    .clr_word_i(wdata_i),
    .active_i  (active_i),
    .queued_i  (queued_i),
    .state_o   (state_q)
  );

  assign slot_req_o   = req_i && (sel == SEL_SLOT);
  assign slot_we_o    = we_i;
  assign slot_wdata_o = wdata_i;

  always_comb begin
    unique case (sel)
      SEL_RAW:   rdata_o = raw_q;
      SEL_MASK:  rdata_o = mask_q;
      SEL_STAT:  rdata_o = raw_q & mask_q;
      SEL_STATE: rdata_o = state_q;
      SEL_SLOT:  rdata_o = slot_rdata_i;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/job_irq_chk.sv
module job_irq_chk #(
  parameter int unsigned NSLOT     = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SLOT_BASE = 'h800,
  localparam int unsigned W        = 2 * NSLOT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [NSLOT-1:0]  done_i,
  input logic [NSLOT-1:0]  fail_i,
  input logic              irq_o,
  input logic              slot_req_o,
  input logic [W-1:0]      raw_q,
  input logic [W-1:0]      mask_q,
  input logic [W-1:0]      state_q
);
  logic [W-1:0]     evt;
  logic             clr_wr;
  logic [NSLOT-1:0] hit;

  assign evt    = {fail_i, done_i};
  assign clr_wr = req_i && we_i && (addr_i == ADDR_W'('h004));
  assign hit    = clr_wr ? (wdata_i[NSLOT-1:0] | wdata_i[W-1:NSLOT]) : '0;

  always_comb begin
    if (!rst_ni) assert_reset_zero_R1: assert (raw_q == '0 && mask_q == '0 && state_q == '0);
  end

  assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_q & $past(evt)) == $past(evt)));

  assert_irq_needs_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0 && raw_q != '0));

  assert_state_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (((state_q ^ $past(state_q)) & ~$past({hit, hit})) == '0));

  assert_state_only_on_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> $stable(state_q));

  assert_slot_fwd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_req_o |-> (req_i && addr_i >= ADDR_W'(SLOT_BASE)));

  assert_no_local_fwd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i < ADDR_W'(SLOT_BASE)) |-> !slot_req_o);
endmodule

bind job_irq_regs job_irq_chk #(
  .NSLOT(NSLOT), .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .done_i(done_i), .fail_i(fail_i),
  .irq_o(irq_o), .slot_req_o(slot_req_o),
  .raw_q(raw_q), .mask_q(mask_q), .state_q(state_q)
);

// File: tb/sim_job_irq_regs.sv
module sim_job_irq_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, slot_wdata_o, slot_rdata_i = '0;
  logic [15:0] done_i = '0, fail_i = '0, active_i = '0, queued_i = '0;
  logic        irq_o, slot_req_o, slot_we_o;
  logic [3:0]  slot_sel_o;
  logic [6:0]  slot_off_o;

  int nchk = 0, nfail = 0;
  logic [31:0] raw_m = '0, mask_m = '0, st_m = '0;
  bit done_flag = 0;

  always #2 clk_i = ~clk_i;

  job_irq_regs u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input logic [31:0] srd);
    if (a >= 12'h800) return srd;
    case (a)
      12'h000: return raw_m;
      12'h008: return mask_m;
      12'h00C: return raw_m & mask_m;
      12'h010: return st_m;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a >= 12'h800) return "R9";
    case (a)
      12'h000: return "R2";
      12'h004: return "R3";
      12'h008: return "R6";
      12'h00C: return "R6";
      12'h010: return "R7";
      default: return "R10";
    endcase
  endfunction

  // one bus cycle: drive at negedge, check combinational outputs, update model at posedge
  task automatic step(input logic rq, input logic w, input logic [11:0] a, input logic [31:0] wd,
                      input logic [15:0] dn, input logic [15:0] fl,
                      input logic [15:0] ac, input logic [15:0] qu, input logic [31:0] srd);
    logic [31:0] clr, set, ev;
    logic [15:0] m;
    @(negedge clk_i);
    req_i = rq; we_i = w; addr_i = a; wdata_i = wd;
    done_i = dn; fail_i = fl; active_i = ac; queued_i = qu; slot_rdata_i = srd;
    #1;
    chk(irq_o == |(raw_m & mask_m), "R6 irq", {31'b0, irq_o}, {31'b0, |(raw_m & mask_m)});
    chk(slot_req_o == (rq && a >= 12'h800), "R9 slot_req", {31'b0, slot_req_o}, {31'b0, rq && a >= 12'h800});
    if (rq && !w) chk(rdata_o == exp_rd(a, srd), tag_of(a), rdata_o, exp_rd(a, srd));
    if (rq && a >= 12'h800) begin
      chk(slot_sel_o == a[10:7], "R9 sel", {28'b0, slot_sel_o}, {28'b0, a[10:7]});
      chk(slot_off_o == a[6:0] && slot_we_o == w && slot_wdata_o == wd, "R9 fwd",
          {25'b0, slot_off_o}, {25'b0, a[6:0]});
    end
    @(posedge clk_i);
    ev  = {fl, dn};
    clr = (rq && w && a == 12'h004) ? wd : '0;
    set = (rq && w && a == 12'h000) ? wd : '0;
    if (rq && w && a == 12'h004) begin
      m = wd[15:0] | wd[31:16];
      st_m = (st_m & ~{m, m}) | {qu & m, ac & m};
    end
    if (rq && w && a == 12'h008) mask_m = wd;
    raw_m = (raw_m & ~clr) | set | ev;
  endtask

  task automatic rd(input logic [11:0] a);
    step(1, 0, a, '0, '0, '0, active_i, queued_i, 32'hDEAD_0000 | 32'(a));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 1, a, d, '0, '0, active_i, queued_i, '0);
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    if (!done_flag) $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #9 rst_ni = 1'b1;
    // R1 reset values
    rd(12'h000); rd(12'h008); rd(12'h00C); rd(12'h010);
    // R2 events
    step(0, 0, '0, '0, 16'h0008, '0, '0, '0, '0);
    step(0, 0, '0, '0, '0, 16'h0020, '0, '0, '0);
    rd(12'h000);
    // R4 clear and event on the same bit
    step(1, 1, 12'h004, 32'h0020_0008, 16'h0008, '0, '0, '0, '0);
    rd(12'h000);
    // R3 plain clear, clear reads zero
    wr(12'h004, 32'h0000_0008);
    rd(12'h000); rd(12'h004);
    // R5 software set
    wr(12'h000, 32'h0001_0001);
    rd(12'h000);
    // R6 mask, status, irq
    wr(12'h008, 32'h0001_0000);
    rd(12'h008); rd(12'h00C);
    wr(12'h008, 32'h0);
    rd(12'h00C);
    // R7 folding: halves name different slots
    step(1, 1, 12'h004, 32'h0004_0001, '0, '0, 16'h0005, 16'h0004, '0);
    rd(12'h010);
    step(1, 1, 12'h004, 32'h0000_0002, '0, '0, 16'hFFFF, 16'h0000, '0);
    rd(12'h010);
    // R8 read-only state and status
    wr(12'h010, 32'hFFFF_FFFF); wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h010); rd(12'h00C);
    // R9 forwarding
    wr(12'h800 + 3 * 12'h80 + 12'h14, 32'hCAFE_F00D);
    rd(12'hFFC); rd(12'h800);
    // R10 unmapped
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020); rd(12'h7FC); rd(12'h000); rd(12'h008);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      int unsigned k = $urandom % 8;
      case (k)
        0: a = 12'h000; 1, 2: a = 12'h004; 3: a = 12'h008;
        4: a = 12'h00C; 5: a = 12'h010; 6: a = 12'h800 | 12'($urandom % 2048);
        default: a = 12'($urandom % 64) << 2;
      endcase
      step($urandom % 4 != 0, $urandom % 2 == 0, a, $urandom,
           16'($urandom) & 16'($urandom), 16'($urandom) & 16'($urandom) & 16'($urandom),
           16'($urandom), 16'($urandom), $urandom);
    end
    rd(12'h010); rd(12'h000);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule